// File: doc/BRIEF.md
# Single-Cycle GHASH Accumulator

This block is the authentication datapath of Galois/Counter Mode. It keeps a 128-bit running hash and, on every clock where a block is presented, folds that block in. The block is XORed into the current hash, and the sum is multiplied by the hash key in GF(2^128). The multiplier is a fully parallel AND/XOR array, so one block is absorbed per clock with no backpressure. The hash key is an input: the surrounding logic derives it from the cipher and holds it steady for the whole message.

A message is fed in a fixed order. The additional authenticated data blocks come first, then the ciphertext blocks, then one length block. The last block of each kind may be partial. A byte count on the data port selects how many leading bytes are kept, and the remaining bytes are cleared to zero before the block is absorbed. A separate strobe carries the two 64-bit bit lengths and absorbs them as the final block. After that block, the hash output is the value that the tag masking stage consumes. A clear input restarts the chain. When clear and a block arrive together, that block becomes the first block of a new message.

Top module: `ghash_accum`

## Requirements
- R1: While `rst` is high at a clock edge, `hash` becomes all zeros and stays zero until a block is absorbed.
- R2: Blocks use this bit order: vector bit 127 is the coefficient of x^0 and is the most significant bit of the first byte; bit 0 is the coefficient of x^127. Absorbing block X turns hash Y into (Y XOR X)·H modulo x^128 + x^7 + x^2 + x + 1, where H is `hkey`. The new value appears on `hash` one clock after the strobe.
- R3: Blocks presented on consecutive clocks are each absorbed, one per clock, with every product depending on the previous hash.
- R4: `clr` without a strobe sets `hash` to zero. `clr` together with a strobe absorbs that block starting from a zero hash.
- R5: `blk_nbytes` gives the number of leading bytes of `blk_data` that are kept (1 to 16). All later bytes are treated as zero. The values 0 and 17 to 31 mean a full 16-byte block.
- R6: `len_valid` absorbs the block {`aad_bits`, `txt_bits`}, with `aad_bits` in bits 127:64 and `txt_bits` in bits 63:0.
- R7: When `len_valid` and `blk_valid` are high together, only the length block is absorbed and `blk_data` has no effect.
- R8: With no strobe and no `clr`, `hash` holds its value.
- R9: With an all-zero cipher key, the key is H = 66e94bd4ef8a2c3b884cfa59ca342b2e. One ciphertext block 0388dace60b6a392f328c2b971b2fe78 then gives 5e2ec746917062882c85b0685353deb7. A length block with no AAD and 128 plaintext bits then gives f38cbb1ad69223dcc3457ae5b6b0f885.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hkey | input | 128 | Hash key H, fixed for the message |
| clr | input | 1 | Restart the chain from zero |
| blk_valid | input | 1 | Absorb `blk_data` this clock |
| blk_data | input | 128 | Data block, first byte in bits 127:120 |
| blk_nbytes | input | 5 | Leading bytes kept (0 or above 16 means 16) |
| len_valid | input | 1 | Absorb the length block this clock |
| aad_bits | input | 64 | AAD length in bits |
| txt_bits | input | 64 | Plaintext length in bits |
| hash | output | 128 | Registered running hash |

## Verification
Four behaviours are checked by assertions on every cycle: the hash holds when idle, a lone clear empties it, an all-zero key forces a zero result, and multiplying by the field identity returns the other operand unchanged. Other properties need chosen stimulus and are shown only by the bench's scenarios. These are the correctness of the field product against an independent schoolbook-and-reduce model, the chaining across back-to-back blocks, the byte masking for every partial length, and the priority of the length block. The bench also replays a published intermediate and final hash value.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int BLK_W  = 128;
  localparam int LEN_W  = BLK_W / 2;
  localparam int BYTES  = BLK_W / 8;
  localparam int NB_W   = $clog2(BYTES) + 1;
  typedef logic [BLK_W-1:0] blk_t;
  // Reduction constant for a one-place right shift in reflected order:
  // x^128 = x^7 + x^2 + x + 1 lands in the top byte as 1110_0001.
  localparam blk_t RED = {8'hE1, {(BLK_W-8){1'b0}}};
endpackage

// File: rtl/ghash_pad.sv
module ghash_pad
  import ghash_pkg::*;
(
  input  blk_t            din,
  input  logic [NB_W-1:0] nbytes,
  output blk_t            dout
);
  int   keep;
  blk_t mask;

  always_comb begin
    if (nbytes == '0 || int'(nbytes) > BYTES) keep = BYTES;
    else keep = int'(nbytes);
    mask = {BLK_W{1'b1}} << (8 * (BYTES - keep));
    dout = din & mask;
  end
endmodule

// File: rtl/gf128_mult.sv
module gf128_mult
  import ghash_pkg::*;
(
  input  blk_t a,
  input  blk_t b,
  output blk_t p
);
  blk_t v [BLK_W];
  blk_t z [BLK_W+1];

  assign v[0] = a;
  assign z[0] = '0;

  genvar i;
  generate
    for (i = 0; i < BLK_W; i++) begin : g_row
      // partial product for coefficient x^i of b
      assign z[i+1] = z[i] ^ (v[i] & {BLK_W{b[BLK_W-1-i]}});
      if (i < BLK_W - 1) begin : g_shift
        assign v[i+1] = {1'b0, v[i][BLK_W-1:1]} ^ (v[i][0] ? RED : '0);
      end
    end
  endgenerate

  assign p = z[BLK_W];

  // R2
  always_comb begin
    if (b == {1'b1, {(BLK_W-1){1'b0}}}) begin
      mult_one_chk: assert (p == a);
    end
  end
endmodule

// File: rtl/ghash_accum.sv
module ghash_accum
  import ghash_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  hkey,
  input  logic              clr,
  input  logic              blk_valid,
  input  logic [BLK_W-1:0]  blk_data,
  input  logic [NB_W-1:0]   blk_nbytes,
  input  logic              len_valid,
  input  logic [LEN_W-1:0]  aad_bits,
  input  logic [LEN_W-1:0]  txt_bits,
  output logic [BLK_W-1:0]  hash
);
  blk_t hash_q, padded, xin, base, prod;
  logic absorb;

  ghash_pad u_pad (.din(blk_data), .nbytes(blk_nbytes), .dout(padded));

  always_comb begin
    absorb = blk_valid | len_valid;
    xin    = len_valid ? {aad_bits, txt_bits} : padded;
    base   = clr ? '0 : hash_q;
  end

  gf128_mult u_mul (.a(base ^ xin), .b(hkey), .p(prod));

  always_ff @(posedge clk) begin
    if (rst)         hash_q <= '0;
    else if (absorb) hash_q <= prod;
    else if (clr)    hash_q <= '0;
  end

  assign hash = hash_q;

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !blk_valid && !len_valid) |=> $stable(hash));

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !blk_valid && !len_valid) |=> (hash == '0));

  // R2
  zero_key_chk: assert property (@(posedge clk) disable iff (rst)
    ((blk_valid || len_valid) && hkey == '0) |=> (hash == '0));
endmodule

// File: tb/ghash_accum_test.sv
module ghash_accum_test;
  import ghash_pkg::*;

  logic clk = 1'b0;
  logic rst, clr, blk_valid, len_valid;
  logic [127:0] hkey, blk_data;
  logic [4:0] blk_nbytes;
  logic [63:0] aad_bits, txt_bits;
  logic [127:0] hash;

  int checks = 0;
  int errors = 0;
  logic [127:0] model;

  always #10 clk = ~clk;

  ghash_accum uut (
    .clk(clk), .rst(rst), .hkey(hkey), .clr(clr), .blk_valid(blk_valid),
    .blk_data(blk_data), .blk_nbytes(blk_nbytes), .len_valid(len_valid),
    .aad_bits(aad_bits), .txt_bits(txt_bits), .hash(hash)
  );

  // schoolbook product on natural polynomials, then reduce from the top
  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [254:0] acc;
    logic [127:0] na, nb, r;
    acc = '0;
    for (int j = 0; j < 128; j++) begin
      na[j] = a[127-j];
      nb[j] = b[127-j];
    end
    for (int j = 0; j < 128; j++)
      if (nb[j]) acc = acc ^ (255'(na) << j);
    for (int d = 254; d >= 128; d--)
      if (acc[d]) begin
        acc[d] = 1'b0;
        acc = acc ^ (255'(135) << (d - 128));
      end
    for (int j = 0; j < 128; j++) r[127-j] = acc[j];
    return r;
  endfunction

  function automatic logic [127:0] pad_ref(input logic [127:0] d, input int n);
    logic [127:0] r;
    int k;
    k = (n == 0 || n > 16) ? 16 : n;
    r = d;
    for (int j = k; j < 16; j++) r[127-8*j -: 8] = 8'h00;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    clr = 0; blk_valid = 0; len_valid = 0;
  endtask

  task automatic check(input string req, input logic [127:0] exp);
    checks++;
    if (hash !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, hash, exp);
    end
  endtask

  task automatic send(input logic c, input logic [127:0] d, input int n);
    clr = c; blk_valid = 1; len_valid = 0; blk_data = d; blk_nbytes = 5'(n);
    model = ref_mul((c ? 128'h0 : model) ^ pad_ref(d, n), hkey);
    tick();
    idle();
  endtask

  // {hkey, block, nbytes}
  localparam logic [260:0] VEC [8] = '{
    {128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0388dace60b6a392f328c2b971b2fe78, 5'd16},
    {128'h80000000000000000000000000000000, 128'hdeadbeef0123456789abcdef55aa33cc, 5'd16},
    {128'h00000000000000000000000000000001, 128'h00000000000000000000000000000001, 5'd16},
    {128'hffffffffffffffffffffffffffffffff, 128'hffffffffffffffffffffffffffffffff, 5'd16},
    {128'hb83b533708bf535d0aa6e52980d53b78, 128'h42831ec2217774244b7221b784d0d49c, 5'd1},
    {128'h25629347589242761d31f826ba4b757b, 128'he3aa212f2c02a4e035c17e2329aca12e, 5'd7},
    {128'h4d5c2af327cd64a62cf35abd2ba6fab4, 128'h21d514b25466931c7d8f6a5aac84aa05, 5'd15},
    {128'hacbef20579b4b8ebce889bac8732dad7, 128'h1ba30b396a0aac973d58e091473f5985, 5'd0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1; hkey = '0; blk_data = '0; blk_nbytes = '0; aad_bits = '0; txt_bits = '0;
    model = '0;
    tick(); tick();
    check("R1", 128'h0);
    rst = 0;
    tick();
    check("R1", 128'h0);

    // table walk: each entry starts a fresh chain with clr (R2, R4, R5)
    for (int i = 0; i < 8; i++) begin
      hkey = VEC[i][260:133];
      send(1'b1, VEC[i][132:5], int'(VEC[i][4:0]));
      check("R2", model);
    end

    // back-to-back chain, no idle cycles (R3)
    hkey = 128'hb83b533708bf535d0aa6e52980d53b78;
    model = '0;
    clr = 1; blk_valid = 1; blk_data = 128'h11111111222222223333333344444444; blk_nbytes = 16;
    model = ref_mul(blk_data, hkey);
    tick();
    check("R3", model);
    clr = 0; blk_data = 128'h0123456789abcdeffedcba9876543210;
    model = ref_mul(model ^ blk_data, hkey);
    tick();
    check("R3", model);
    blk_data = 128'h5555aaaa5555aaaa5555aaaa5555aaaa;
    model = ref_mul(model ^ blk_data, hkey);
    tick();
    check("R3", model);
    idle();

    // idle hold (R8)
    tick(); tick();
    check("R8", model);

    // every partial byte count on a running chain (R5)
    for (int n = 1; n <= 17; n++) begin
      send(1'b0, 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f, n);
      check("R5", model);
    end

    // length block (R6)
    clr = 0; len_valid = 1; aad_bits = 64'h00000000000000a0; txt_bits = 64'h00000000000001e0;
    model = ref_mul(model ^ {aad_bits, txt_bits}, hkey);
    tick(); idle();
    check("R6", model);

    // length wins over a simultaneous data block (R7)
    len_valid = 1; blk_valid = 1; blk_data = 128'hffff0000ffff0000ffff0000ffff0000; blk_nbytes = 16;
    aad_bits = 64'h0000000000000080; txt_bits = 64'h0000000000000200;
    model = ref_mul(model ^ {aad_bits, txt_bits}, hkey);
    tick(); idle();
    check("R7", model);

    // lone clear (R4)
    clr = 1;
    tick(); idle();
    model = '0;
    check("R4", 128'h0);

    // published intermediate and final values (R9)
    hkey = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    clr = 1; blk_valid = 1; blk_data = 128'h0388dace60b6a392f328c2b971b2fe78; blk_nbytes = 16;
    tick(); idle();
    check("R9", 128'h5e2ec746917062882c85b0685353deb7);
    len_valid = 1; aad_bits = 64'h0; txt_bits = 64'h80;
    tick(); idle();
    check("R9", 128'hf38cbb1ad69223dcc3457ae5b6b0f885);

    // reset mid-message (R1)
    rst = 1;
    tick();
    rst = 0;
    check("R1", 128'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule